// File: doc/BRIEF.md
# Protection Region Range Decoder

This block sits next to a memory protection unit and converts each protection entry's settings into a pair of inclusive byte addresses. Every entry has a two-bit match mode and a 32-bit address register that holds bits 33:2 of a 34-bit physical address. The block turns each entry into a start and an end address that a downstream comparator can test directly. For the top-of-range mode it also reads the address register of the entry below. It reports which entries are enabled and how many there are.

The decode is a purely combinational slice, repeated once per entry, with registered outputs. The owner of the configuration pulses `cfgChanged` for one cycle after it writes any mode or address. In the next cycle the block captures every range at once and drops `rangesValid` for that cycle. From the edge after that, the outputs hold steady until the next pulse. Input changes without a pulse leave the outputs as they are.

Top module: `pmp_range_decoder`

## Requirements
- R1: After reset, `rangesValid` is 0, and every start, end, active bit and the active count are 0.
- R2: If `cfgChanged` is high at clock edge k, `rangesValid` is 0 after edge k. The outputs hold the ranges decoded from the inputs present at edge k+1, and if `cfgChanged` is low at k+1, `rangesValid` is 1 after edge k+1. While no pulse arrives, the outputs and `rangesValid` stay unchanged even if the inputs change.
- R3: Mode 0 (off) in the entry's 2-bit field `matchModes[2i+1:2i]` gives start 0, end 0 and active bit 0.
- R4: Mode 1 (top of range) gives start = previous entry's register × 4 and end = (own register × 4) − 1, taken modulo 2^34. Entry 0 uses 0 as its previous register.
- R5: In mode 1, if the computed start exceeds the computed end, both start and end become 0. The active bit stays 1.
- R6: Mode 2 (naturally aligned four bytes) gives start = register × 4 and end = start + 3.
- R7: Mode 3 (naturally aligned power of two) sets the region size to 2^(t+3) bytes, where t is the number of trailing one bits in the register. The start is register × 4 with its low t+3 bits cleared, and the end is start + size − 1. An all-ones register covers the whole space from 0 to 2^34 − 1.
- R8: `activeMask` bit i is 1 exactly when entry i's mode is not 0. `activeCount` equals the number of such entries.
- R9: A new value in entry i's register, followed by a pulse, also moves the start of entry i+1 when that entry is in mode 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfgChanged | input | 1 | One-cycle pulse after any configuration change |
| matchModes | input | 2·NUM_ENTRIES | Match mode per entry, entry i in bits 2i+1:2i |
| addrRegs | input | NUM_ENTRIES·(PA_WIDTH−2) | Address register per entry, entry i in slice i |
| rangeStarts | output | NUM_ENTRIES·PA_WIDTH | Inclusive start byte address per entry |
| rangeEnds | output | NUM_ENTRIES·PA_WIDTH | Inclusive end byte address per entry |
| activeMask | output | NUM_ENTRIES | Entry enabled (mode not off) |
| activeCount | output | clog2(NUM_ENTRIES+1) | Number of enabled entries |
| rangesValid | output | 1 | Outputs reflect the latest configuration |

## Verification
The bench builds the block with four entries and the default 34-bit address width. Four entries are enough to put entry 0's implicit zero lower bound, a chain of neighbouring top-of-range entries and the last entry all in one configuration. The full 34-bit width brings the extreme values into reach: wrap-around of a zero top-of-range register, an aligned four-byte block at the very top of the address space, and the all-ones power-of-two register that spans the whole space.

// File: rtl/pmp_rng_pkg.sv
package pmp_rng_pkg;

  typedef enum logic [1:0] {
    MATCH_OFF   = 2'd0,
    MATCH_TOR   = 2'd1,
    MATCH_NA4   = 2'd2,
    MATCH_NAPOT = 2'd3
  } matchMode_e;

  typedef struct packed {
    logic capture;
  } rngStrobe_t;

endpackage

// File: rtl/pmp_rng_entry.sv
module pmp_rng_entry
  import pmp_rng_pkg::*;
#(
  parameter int PA_WIDTH = 34
) (
  input  logic [1:0]          mode,
  input  logic [PA_WIDTH-3:0] addrReg,
  input  logic [PA_WIDTH-3:0] prevAddrReg,
  output logic [PA_WIDTH-1:0] rngStart,
  output logic [PA_WIDTH-1:0] rngEnd,
  output logic                active
);

  logic [PA_WIDTH-1:0] byteAddr;
  logic [PA_WIDTH-1:0] prevByteAddr;
  logic [PA_WIDTH-1:0] torEnd;
  logic [PA_WIDTH-1:0] napotVal;
  logic [PA_WIDTH-1:0] napotInc;

  always_comb begin
    byteAddr     = {addrReg, 2'b00};
    prevByteAddr = {prevAddrReg, 2'b00};
    torEnd       = byteAddr - PA_WIDTH'(1);
    napotVal     = {addrReg, 2'b11};
    napotInc     = napotVal + PA_WIDTH'(1);
    rngStart     = '0;
    rngEnd       = '0;
    active       = 1'b1;
    unique case (matchMode_e'(mode))
      MATCH_OFF: begin
        active = 1'b0;
      end
      MATCH_TOR: begin
        if (prevByteAddr <= torEnd) begin
          rngStart = prevByteAddr;
          rngEnd   = torEnd;
        end
      end
      MATCH_NA4: begin
        rngStart = byteAddr;
        rngEnd   = byteAddr + PA_WIDTH'(3);
      end
      MATCH_NAPOT: begin
        rngStart = napotVal & napotInc;
        rngEnd   = napotVal | napotInc;
      end
      default: active = 1'b0;
    endcase
  end

endmodule

// File: rtl/pmp_rng_ctrl.sv
module pmp_rng_ctrl
  import pmp_rng_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfgChanged,
  output rngStrobe_t strobe,
  output logic       rangesValid
);

  logic pendQ;
  logic validQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pendQ  <= 1'b0;
      validQ <= 1'b0;
    end else begin
      pendQ <= cfgChanged;
      if (cfgChanged) begin
        validQ <= 1'b0;
      end else if (pendQ) begin
        validQ <= 1'b1;
      end
    end
  end

  always_comb begin
    strobe.capture = pendQ;
  end

  assign rangesValid = validQ;

  AST_INVALID_AFTER_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cfgChanged |=> !rangesValid); // R2

  AST_VALID_AFTER_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.capture && !cfgChanged) |=> rangesValid); // R2

  AST_VALID_NEEDS_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe.capture && !rangesValid) |=> !rangesValid); // R2

endmodule

// File: rtl/pmp_rng_datapath.sv
module pmp_rng_datapath
  import pmp_rng_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int PA_WIDTH    = 34
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  rngStrobe_t                           strobe,
  input  logic [2*NUM_ENTRIES-1:0]             matchModes,
  input  logic [NUM_ENTRIES*(PA_WIDTH-2)-1:0]  addrRegs,
  output logic [NUM_ENTRIES*PA_WIDTH-1:0]      rangeStarts,
  output logic [NUM_ENTRIES*PA_WIDTH-1:0]      rangeEnds,
  output logic [NUM_ENTRIES-1:0]               activeMask,
  output logic [$clog2(NUM_ENTRIES+1)-1:0]     activeCount
);

  localparam int AW = PA_WIDTH - 2;
  localparam int CW = $clog2(NUM_ENTRIES + 1);

  logic [PA_WIDTH-1:0] startNext [NUM_ENTRIES];
  logic [PA_WIDTH-1:0] endNext   [NUM_ENTRIES];
  logic [PA_WIDTH-1:0] startQ    [NUM_ENTRIES];
  logic [PA_WIDTH-1:0] endQ      [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] activeNext;
  logic [NUM_ENTRIES-1:0] activeQ;
  logic [CW-1:0]          countNext;
  logic [CW-1:0]          countQ;

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : gEntry
    logic [AW-1:0] prevAddr;
    if (g == 0) begin : gFirst
      assign prevAddr = '0;
    end else begin : gChained
      assign prevAddr = addrRegs[(g-1)*AW +: AW];
    end

    pmp_rng_entry #(.PA_WIDTH(PA_WIDTH)) u_entry (
      .mode        (matchModes[2*g +: 2]),
      .addrReg     (addrRegs[g*AW +: AW]),
      .prevAddrReg (prevAddr),
      .rngStart    (startNext[g]),
      .rngEnd      (endNext[g]),
      .active      (activeNext[g])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        startQ[g] <= '0;
        endQ[g]   <= '0;
      end else if (strobe.capture) begin
        startQ[g] <= startNext[g];
        endQ[g]   <= endNext[g];
      end
    end

    assign rangeStarts[g*PA_WIDTH +: PA_WIDTH] = startQ[g];
    assign rangeEnds[g*PA_WIDTH +: PA_WIDTH]   = endQ[g];

    AST_ACTIVE_ORDERED: assert property (@(posedge clk) disable iff (!rst_n)
      activeQ[g] |-> (startQ[g] <= endQ[g])); // R5

    AST_OFF_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !activeQ[g] |-> (startQ[g] == '0 && endQ[g] == '0)); // R3

    AST_HOLD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe.capture |=> ($stable(startQ[g]) && $stable(endQ[g]))); // R2
  end

  always_comb begin
    countNext = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      countNext = countNext + CW'(activeNext[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      activeQ <= '0;
      countQ  <= '0;
    end else if (strobe.capture) begin
      activeQ <= activeNext;
      countQ  <= countNext;
    end
  end

  assign activeMask  = activeQ;
  assign activeCount = countQ;

  AST_COUNT_MATCHES_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    32'(activeCount) == $countones(activeMask)); // R8

endmodule

// File: rtl/pmp_range_decoder.sv
module pmp_range_decoder
  import pmp_rng_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int PA_WIDTH    = 34
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 cfgChanged,
  input  logic [2*NUM_ENTRIES-1:0]             matchModes,
  input  logic [NUM_ENTRIES*(PA_WIDTH-2)-1:0]  addrRegs,
  output logic [NUM_ENTRIES*PA_WIDTH-1:0]      rangeStarts,
  output logic [NUM_ENTRIES*PA_WIDTH-1:0]      rangeEnds,
  output logic [NUM_ENTRIES-1:0]               activeMask,
  output logic [$clog2(NUM_ENTRIES+1)-1:0]     activeCount,
  output logic                                 rangesValid
);

  rngStrobe_t strobe;

  pmp_rng_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfgChanged  (cfgChanged),
    .strobe      (strobe),
    .rangesValid (rangesValid)
  );

  pmp_rng_datapath #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .PA_WIDTH    (PA_WIDTH)
  ) u_datapath (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe      (strobe),
    .matchModes  (matchModes),
    .addrRegs    (addrRegs),
    .rangeStarts (rangeStarts),
    .rangeEnds   (rangeEnds),
    .activeMask  (activeMask),
    .activeCount (activeCount)
  );

endmodule

// File: tb/pmp_range_decoder_bench.sv
module pmp_range_decoder_bench;

  localparam int N  = 4;
  localparam int PA = 34;
  localparam int AW = PA - 2;
  localparam longint MASK = 64'h3_FFFF_FFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfgChanged = 1'b0;
  logic [2*N-1:0]  modes = '0;
  logic [N*AW-1:0] addrs = '0;
  logic [N*PA-1:0] rangeStarts;
  logic [N*PA-1:0] rangeEnds;
  logic [N-1:0]    activeMask;
  logic [2:0]      activeCount;
  logic            rangesValid;

  always #10 clk = ~clk;

  pmp_range_decoder #(.NUM_ENTRIES(N), .PA_WIDTH(PA)) u_pmp_range_decoder (
    .clk(clk), .rst_n(rst_n), .cfgChanged(cfgChanged),
    .matchModes(modes), .addrRegs(addrs),
    .rangeStarts(rangeStarts), .rangeEnds(rangeEnds),
    .activeMask(activeMask), .activeCount(activeCount),
    .rangesValid(rangesValid)
  );

  typedef struct {
    int     idx;
    longint s;
    longint e;
    bit     act;
    int     cnt;
    string  req;
  } item_t;

  item_t  sbQ[$];
  int     testsRun = 0;
  int     testsFailed = 0;
  bit     finished = 0;
  longint expS [N];
  longint expE [N];
  bit     expA [N];
  int     expCnt;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Reference model built from the requirement text.
  task automatic computeExpected();
    expCnt = 0;
    for (int i = 0; i < N; i++) begin
      longint a, p, size;
      int t;
      a = longint'(addrs[i*AW +: AW]);
      p = (i == 0) ? 0 : longint'(addrs[(i-1)*AW +: AW]);
      expS[i] = 0; expE[i] = 0; expA[i] = 1;
      case (modes[2*i +: 2])
        2'd0: expA[i] = 0;
        2'd1: begin
          expS[i] = (p * 4) & MASK;
          expE[i] = (a * 4 - 1) & MASK;
          if (expS[i] > expE[i]) begin expS[i] = 0; expE[i] = 0; end
        end
        2'd2: begin expS[i] = a * 4; expE[i] = a * 4 + 3; end
        default: begin
          t = 0;
          while (t < AW && a[t]) t++;
          size = longint'(1) << (t + 3);
          expS[i] = (a * 4) & ~(size - 1) & MASK;
          expE[i] = (expS[i] + size - 1) & MASK;
        end
      endcase
      if (expA[i]) expCnt++;
    end
  endtask

  task automatic runCase(input string req);
    computeExpected();
    for (int i = 0; i < N; i++) begin
      item_t it;
      it.idx = i; it.s = expS[i]; it.e = expE[i]; it.act = expA[i];
      it.cnt = expCnt; it.req = req;
      sbQ.push_back(it);
    end
    cfgChanged = 1'b1;
    @(negedge clk);
    cfgChanged = 1'b0;
    check(rangesValid == 1'b0, "R2", "valid low after pulse", rangesValid, 0);
    repeat (3) @(negedge clk);
    #1;
    check(sbQ.size() == 0, req, "scoreboard drained", sbQ.size(), 0);
    check(rangesValid == 1'b1, "R2", "valid high after capture", rangesValid, 1);
  endtask

  // Monitor: compares captured ranges when valid rises.
  bit prevValid = 0;
  always @(negedge clk) begin
    if (rangesValid && !prevValid) begin
      for (int i = 0; i < N; i++) begin
        if (sbQ.size() == 0) begin
          check(0, "R2", "unexpected result", i, -1);
        end else begin
          item_t it;
          longint aS, aE;
          it = sbQ.pop_front();
          aS = longint'(rangeStarts[it.idx*PA +: PA]);
          aE = longint'(rangeEnds[it.idx*PA +: PA]);
          check(aS == it.s, it.req, $sformatf("entry %0d start", it.idx), aS, it.s);
          check(aE == it.e, it.req, $sformatf("entry %0d end", it.idx), aE, it.e);
          check(activeMask[it.idx] == it.act, "R8",
                $sformatf("entry %0d active", it.idx), activeMask[it.idx], it.act);
          if (it.idx == 0)
            check(int'(activeCount) == it.cnt, "R8", "active count", activeCount, it.cnt);
        end
      end
    end
    prevValid = rangesValid;
  end

  task automatic setEntry(input int i, input logic [1:0] m, input logic [AW-1:0] a);
    modes[2*i +: 2] = m;
    addrs[i*AW +: AW] = a;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(rangesValid == 0, "R1", "valid after reset", rangesValid, 0);
    check(activeCount == 0, "R1", "count after reset", activeCount, 0);
    check(activeMask == 0, "R1", "mask after reset", activeMask, 0);
    check(rangeStarts == 0 && rangeEnds == 0, "R1", "ranges after reset",
          longint'(rangeEnds[PA-1:0]), 0);

    // R3: every entry off, addresses nonzero
    for (int i = 0; i < N; i++) setEntry(i, 2'd0, 32'h1234_5670 + i);
    runCase("R3");

    // R4 R5 R6 R7: mixed modes, entry 3 collapses
    setEntry(0, 2'd1, 32'h0000_0100);
    setEntry(1, 2'd2, 32'h0000_0200);
    setEntry(2, 2'd3, 32'h0000_0403);
    setEntry(3, 2'd1, 32'h0000_0180);
    runCase("R5");

    // R2: inputs move without a pulse; outputs must hold
    setEntry(0, 2'd0, 32'hDEAD_BEEF);
    setEntry(2, 2'd2, 32'h0000_0010);
    repeat (4) @(negedge clk);
    check(rangesValid == 1, "R2", "valid holds", rangesValid, 1);
    check(longint'(rangeStarts[2*PA +: PA]) == 64'h1000, "R2", "entry 2 start holds",
          longint'(rangeStarts[2*PA +: PA]), 64'h1000);
    check(activeCount == 3'd4, "R2", "count holds", activeCount, 4);

    // R4 R6 R7: wrap, top of space, whole space, 8-byte region
    setEntry(0, 2'd3, 32'hFFFF_FFFE);
    setEntry(1, 2'd2, 32'hFFFF_FFFF);
    setEntry(2, 2'd3, 32'hFFFF_FFFF);
    setEntry(3, 2'd1, 32'h0000_0000);
    runCase("R7");

    // R4: entry 0 top-of-range from zero, chained neighbour
    setEntry(0, 2'd1, 32'h0000_4000);
    setEntry(1, 2'd1, 32'h0000_8000);
    setEntry(2, 2'd0, 32'h0000_9000);
    setEntry(3, 2'd3, 32'h0001_00FF);
    runCase("R4");

    // R9: only entry 0 register moves; entry 1 start follows
    setEntry(0, 2'd1, 32'h0000_6000);
    runCase("R9");
    check(longint'(rangeStarts[PA +: PA]) == 64'h1_8000, "R9", "neighbour start",
          longint'(rangeStarts[PA +: PA]), 64'h1_8000);

    // R6 R8: two active entries only
    setEntry(0, 2'd0, 32'h0);
    setEntry(1, 2'd2, 32'h0000_0001);
    setEntry(2, 2'd0, 32'h0000_0005);
    setEntry(3, 2'd2, 32'h8000_0000);
    runCase("R6");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule